// File: doc/BRIEF.md
# Video Memory Address Mirroring Unit

This unit sits on the video bus of a tile-based picture processor. It takes each 16-bit bus request and steers it to one of three targets. Low addresses hold pattern data and pass unchanged to an external cartridge port. The middle window reaches 2 KiB of background map RAM. The top window reaches 32 bytes of colour palette RAM. Requests above the video space are rejected and flagged.

Four logical 1 KiB background maps share the 2 KiB map RAM. A 3-bit folding-mode input decides which physical half each logical map uses, and it can change between any two accesses. The palette aliases the backdrop slots of the sprite palettes onto the matching background entries.

Reads return data one cycle after the request. Writes finish in the cycle they are presented and never stall.

Top module: `vram_mirror_unit`

## Requirements
- R1: A request with address below 0x2000 asserts cart_valid in the same cycle, with cart_addr equal to address bits [12:0] and cart_write and cart_wdata copied from the request. For a read, rsp_rdata in the next cycle equals cart_rdata in that cycle.
- R2: Addresses 0x2000 to 0x3EFF reach map RAM using offset (address − 0x2000) & 0x0FFF. Bits [11:10] of the offset are the logical map and bits [9:0] are the byte within it, so 0x3000–0x3EFF mirror 0x2000–0x2EFF.
- R3: In mode 0, logical maps 0,1 use physical half 0 and logical maps 2,3 use physical half 1.
- R4: In mode 1, logical maps 0,2 use physical half 0 and logical maps 1,3 use physical half 1.
- R5: In mode 2, every logical map uses physical half 0. In mode 3, every logical map uses physical half 1.
- R6: In mode 4, and in modes 5 to 7, logical map n selects physical block n. The RAM index keeps only 11 bits, so blocks 2 and 3 fold onto halves 0 and 1.
- R7: The folding mode is taken from mirror_mode in the cycle of each request. A mode change takes effect on the very next access.
- R8: Addresses 0x3F00 to 0x3FFF reach palette RAM at index address[4:0].
- R9: A palette index of 0x10 or more whose two low bits are zero loses 0x10. So 0x10, 0x14, 0x18 and 0x1C share storage with 0x00, 0x04, 0x08 and 0x0C.
- R10: A request at 0x4000 or above raises range_err for exactly the following cycle. It leaves cart_valid low and changes no RAM. If it is a read, it returns rsp_rdata of 0x00.
- R11: rsp_valid is high in the cycle after each read request and low in every other cycle. After reset, rsp_valid, range_err and cart_valid are low.
- R12: A write finishes in one cycle. A read of the same location, or of an aliased location, presented in the next cycle returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Video bus address |
| req_wdata | input | 8 | Write data |
| mirror_mode | input | 3 | Map folding mode (0 horiz, 1 vert, 2 single low, 3 single high, 4–7 four-map) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| range_err | output | 1 | Previous request was out of range |
| cart_valid | output | 1 | Request forwarded to cartridge port |
| cart_write | output | 1 | Forwarded write strobe |
| cart_addr | output | 13 | Forwarded pattern address |
| cart_wdata | output | 8 | Forwarded write data |
| cart_rdata | input | 8 | Cartridge read data, one cycle after request |

## Verification
Two things can meet in one cycle: a change of folding mode and a map access, or a write followed at once by a read of an aliased location. The bench issues back-to-back operations with a fresh random mode on every request. A write is often followed directly by a read of its mirror partner. A bench model folds each address with the mode of that request and predicts the byte returned. Directed sequences cover each mode's table, the palette alias pairs, the 0x3000 mirror window and the out-of-range edge at 0x4000.

// File: rtl/vmm_pkg.sv
package vmm_pkg;

    typedef enum logic [1:0] {
        RGN_CART = 2'd0,
        RGN_MAP  = 2'd1,
        RGN_PAL  = 2'd2,
        RGN_BAD  = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        FOLD_HORIZ  = 3'd0,
        FOLD_VERT   = 3'd1,
        FOLD_LOW    = 3'd2,
        FOLD_HIGH   = 3'd3,
        FOLD_FOUR   = 3'd4
    } fold_e;

    // registered response bookkeeping for the read pipeline stage
    typedef struct packed {
        logic    rsp_valid;
        logic    err;
        region_e src;
    } rsp_state_t;

endpackage

// File: rtl/vmm_decode.sv
module vmm_decode
    import vmm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MAP_AW = 11,
    parameter int PAL_AW = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        mode,
    output region_e           region,
    output logic [MAP_AW-1:0] map_idx,
    output logic [PAL_AW-1:0] pal_idx
);
    localparam logic [ADDR_W-1:0] MAP_BASE = ADDR_W'(16'h2000);
    localparam logic [ADDR_W-1:0] PAL_BASE = ADDR_W'(16'h3F00);
    localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(17'h4000);
    localparam int OFS_W = 10;

    logic [11:0]       rel;
    logic [1:0]        logical;
    logic [1:0]        phys;
    logic [11:0]       folded;
    logic [PAL_AW-1:0] praw;

    always_comb begin
        if (addr < MAP_BASE)       region = RGN_CART;
        else if (addr < PAL_BASE)  region = RGN_MAP;
        else if (addr < END_ADDR)  region = RGN_PAL;
        else                       region = RGN_BAD;
    end

    // base 0x2000 has zero low bits, so (addr - base) & 0xFFF is addr[11:0]
    assign rel     = addr[11:0];
    assign logical = rel[11:10];

    always_comb begin
        case (mode)
            FOLD_HORIZ: phys = {1'b0, logical[1]};
            FOLD_VERT:  phys = {1'b0, logical[0]};
            FOLD_LOW:   phys = 2'd0;
            FOLD_HIGH:  phys = 2'd1;
            default:    phys = logical;   // four-map, also codes 5..7
        endcase
    end

    assign folded  = {phys, rel[OFS_W-1:0]};
    assign map_idx = folded[MAP_AW-1:0];

    // backdrop slots of the upper palettes collapse onto the lower ones
    assign praw = addr[PAL_AW-1:0];
    always_comb begin
        pal_idx = praw;
        if (praw[PAL_AW-1] && (praw[1:0] == 2'b00))
            pal_idx[PAL_AW-1] = 1'b0;
    end

endmodule

// File: rtl/vmm_ram.sv
module vmm_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/vram_mirror_unit.sv
module vram_mirror_unit
    import vmm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int MAP_AW = 11,
    parameter int PAL_AW = 5,
    parameter int CART_AW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [2:0]        mirror_mode,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              range_err,
    output logic              cart_valid,
    output logic              cart_write,
    output logic [CART_AW-1:0] cart_addr,
    output logic [DATA_W-1:0] cart_wdata,
    input  logic [DATA_W-1:0] cart_rdata
);
    region_e           region;
    logic [MAP_AW-1:0] map_idx;
    logic [PAL_AW-1:0] pal_idx;
    logic [DATA_W-1:0] map_rdata;
    logic [DATA_W-1:0] pal_rdata;
    logic              hit_map;
    logic              hit_pal;
    rsp_state_t        st_d;
    rsp_state_t        st_q;

    vmm_decode #(
        .ADDR_W (ADDR_W),
        .MAP_AW (MAP_AW),
        .PAL_AW (PAL_AW)
    ) u_decode (
        .addr    (req_addr),
        .mode    (mirror_mode),
        .region  (region),
        .map_idx (map_idx),
        .pal_idx (pal_idx)
    );

    assign hit_map = req_valid && (region == RGN_MAP);
    assign hit_pal = req_valid && (region == RGN_PAL);

    vmm_ram #(.AW(MAP_AW), .DW(DATA_W)) u_map_ram (
        .clk   (clk),
        .we    (hit_map && req_write),
        .re    (hit_map && !req_write),
        .addr  (map_idx),
        .wdata (req_wdata),
        .rdata (map_rdata)
    );

    vmm_ram #(.AW(PAL_AW), .DW(DATA_W)) u_pal_ram (
        .clk   (clk),
        .we    (hit_pal && req_write),
        .re    (hit_pal && !req_write),
        .addr  (pal_idx),
        .wdata (req_wdata),
        .rdata (pal_rdata)
    );

    // pattern window passes straight through to the cartridge side
    assign cart_valid = req_valid && (region == RGN_CART);
    assign cart_write = req_write;
    assign cart_addr  = req_addr[CART_AW-1:0];
    assign cart_wdata = req_wdata;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid && !req_write;
        st_d.err       = req_valid && (region == RGN_BAD);
        st_d.src       = region;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rsp_valid: 1'b0, err: 1'b0, src: RGN_BAD};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign range_err = st_q.err;

    always_comb begin
        case (st_q.src)
            RGN_CART: rsp_rdata = cart_rdata;
            RGN_MAP:  rsp_rdata = map_rdata;
            RGN_PAL:  rsp_rdata = pal_rdata;
            default:  rsp_rdata = '0;
        endcase
    end

endmodule

// File: rtl/vmm_checker.sv
module vmm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [15:0] req_addr,
    input logic [7:0]  req_wdata,
    input logic        rsp_valid,
    input logic [7:0]  rsp_rdata,
    input logic        range_err,
    input logic        cart_valid
);
    AST_CART_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cart_valid |-> (req_valid && req_addr < 16'h2000)); // R1

    AST_CART_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr < 16'h2000) |-> cart_valid); // R1

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R11

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R11

    AST_RANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= 16'h4000) |=> range_err); // R10

    AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (range_err && rsp_valid) |-> (rsp_rdata == 8'h00)); // R10

    AST_NO_CART_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= 16'h4000) |-> !cart_valid); // R10

    AST_PAL_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 16'h3F10 &&
         $past(req_valid && req_write && req_addr == 16'h3F00))
        |=> (rsp_rdata == $past(req_wdata, 2))); // R9
endmodule

bind vram_mirror_unit vmm_checker u_vmm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .range_err  (range_err),
    .cart_valid (cart_valid)
);

// File: tb/tb_vram_mirror_unit.sv
module tb_vram_mirror_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic [2:0]  mirror_mode;
    logic        rsp_valid, range_err;
    logic [7:0]  rsp_rdata;
    logic        cart_valid, cart_write;
    logic [12:0] cart_addr;
    logic [7:0]  cart_wdata;
    logic [7:0]  cart_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] map_m [2048];
    logic [7:0] pal_m [32];

    bit         pend_read = 0;
    bit         pend_err  = 0;
    logic [7:0] pend_data = 0;
    string      pend_tag  = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    vram_mirror_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .mirror_mode(mirror_mode),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .range_err(range_err),
        .cart_valid(cart_valid), .cart_write(cart_write), .cart_addr(cart_addr),
        .cart_wdata(cart_wdata), .cart_rdata(cart_rdata)
    );

    // cartridge model: answers one cycle after a forwarded read
    always @(posedge clk)
        cart_rdata <= (cart_valid && !cart_write) ? (cart_addr[7:0] ^ 8'hA5) : 8'h00;

    function automatic int exp_map(input logic [2:0] m, input logic [15:0] a);
        logic [11:0] rel;
        logic        half;
        rel = 12'((a - 16'h2000) & 16'h0FFF);
        case (m)
            3'd0: half = rel[11];
            3'd1: half = rel[10];
            3'd2: half = 1'b0;
            3'd3: half = 1'b1;
            default: half = rel[10];   // block n masked to 11 bits
        endcase
        return {half, rel[9:0]};
    endfunction

    function automatic int exp_pal(input logic [15:0] a);
        int i;
        i = a & 16'h1F;
        if (i >= 16 && (i % 4) == 0) i = i - 16;
        return i;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one operation per cycle: checks the previous op's response, drives a new one
    task automatic step(input bit v, input bit w, input logic [15:0] a,
                        input logic [7:0] d, input logic [2:0] m, input string tag);
        @(negedge clk);
        check(rsp_valid == pend_read, {pend_tag, " rsp_valid"}, rsp_valid, pend_read);
        check(range_err == pend_err, {pend_tag, " range_err"}, range_err, pend_err);
        if (pend_read)
            check(rsp_rdata == pend_data, {pend_tag, " rdata"}, rsp_rdata, pend_data);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; mirror_mode = m;
        pend_read = v && !w;
        pend_err  = v && (a >= 16'h4000);
        pend_tag  = tag;
        pend_data = 8'h00;
        #1;
        if (v && a < 16'h2000) begin
            check(cart_valid && cart_addr == a[12:0] && cart_write == w &&
                  cart_wdata == d, {tag, " R1 forward"}, cart_addr, a[12:0]);
            pend_data = a[7:0] ^ 8'hA5;
        end else begin
            check(!cart_valid, {tag, " cart idle"}, cart_valid, 0);
        end
        if (v && a >= 16'h2000 && a < 16'h3F00) begin
            if (w) map_m[exp_map(m, a)] = d;
            else   pend_data = map_m[exp_map(m, a)];
        end else if (v && a >= 16'h3F00 && a < 16'h4000) begin
            if (w) pal_m[exp_pal(a)] = d;
            else   pend_data = pal_m[exp_pal(a)];
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [2:0] m, input string t);
        step(1, 1, a, d, m, t);
    endtask
    task automatic rd(input logic [15:0] a, input logic [2:0] m, input string t);
        step(1, 0, a, 8'h00, m, t);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; mirror_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 0 && range_err == 0 && cart_valid == 0, "R11 reset", rsp_valid, 0);
        rst_n = 1;

        // fill both RAMs so every later read has a known value
        for (int i = 0; i < 2048; i++) wr(16'(16'h2000 + i), 8'(i * 7 + 3), 3'd4, "R6 fill");
        for (int i = 0; i < 32; i++)   wr(16'(16'h3F00 + i), 8'(i + 8'h40), 3'd0, "R8 fill");

        // R3 horizontal: maps 0,1 share, 2,3 share
        wr(16'h2005, 8'h11, 3'd0, "R3");
        rd(16'h2405, 3'd0, "R3 map1=map0");
        wr(16'h2805, 8'h22, 3'd0, "R3");
        rd(16'h2C05, 3'd0, "R3 map3=map2");
        rd(16'h2005, 3'd0, "R3 map0 kept");
        // R4 vertical
        wr(16'h2010, 8'h33, 3'd1, "R4");
        rd(16'h2810, 3'd1, "R4 map2=map0");
        wr(16'h2410, 8'h44, 3'd1, "R4");
        rd(16'h2C10, 3'd1, "R4 map3=map1");
        // R5 single low / high
        wr(16'h2C20, 8'h55, 3'd2, "R5");
        rd(16'h2020, 3'd2, "R5 low all");
        wr(16'h2020, 8'h66, 3'd3, "R5");
        rd(16'h2820, 3'd3, "R5 high all");
        // R6 four-map and codes 5..7
        wr(16'h2830, 8'h77, 3'd4, "R6");
        rd(16'h2030, 3'd5, "R6 block2 folds");
        rd(16'h2C30, 3'd7, "R6 block3 = half1");
        // R2 mirror window
        wr(16'h3123, 8'h88, 3'd1, "R2");
        rd(16'h2123, 3'd1, "R2 0x3xxx mirror");
        rd(16'h3EFF, 3'd0, "R2 top of map");
        // R7 mode change between back-to-back accesses
        wr(16'h2440, 8'h99, 3'd1, "R7");
        rd(16'h2440, 3'd0, "R7 new mode at once");
        // R9 palette aliases, R8 palette window
        for (int k = 0; k < 4; k++) begin
            wr(16'(16'h3F10 + 4*k), 8'(8'hC0 + k), 3'd0, "R9");
            rd(16'(16'h3F00 + 4*k), 3'd0, "R9 alias");
        end
        wr(16'h3F11, 8'hD1, 3'd0, "R9 nonalias");
        rd(16'h3F01, 3'd0, "R9 0x01 untouched");
        rd(16'h3FF1, 3'd0, "R8 low 5 bits");
        // R10 range edge
        rd(16'h3FFF, 3'd0, "R10 last valid");
        wr(16'h4000, 8'hEE, 3'd0, "R10 bad write");
        rd(16'hFFFF, 3'd0, "R10 bad read");
        rd(16'h3F00, 3'd0, "R10 RAM untouched");
        // R1 pattern region
        rd(16'h0000, 3'd0, "R1");
        wr(16'h1FFF, 8'h5C, 3'd0, "R1");
        rd(16'h1ABC, 3'd0, "R1");
        // R12 write then read next cycle, R11 idle
        wr(16'h2777, 8'h3C, 3'd4, "R12");
        rd(16'h2777, 3'd4, "R12 no wait");
        step(0, 0, 16'h0000, 8'h00, 3'd0, "R11 idle");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [15:0] a;
            r = $urandom % 10;
            case (r)
                0, 1:    a = 16'($urandom % 16'h2000);
                2, 3, 4: a = 16'(16'h2000 + ($urandom % 16'h1000));
                5:       a = 16'(16'h3000 + ($urandom % 16'h0F00));
                6, 7:    a = 16'(16'h3F00 + ($urandom % 256));
                8:       a = 16'(16'h4000 + ($urandom % 16'hC000));
                default: a = 16'(16'h2000 + ($urandom % 16'h1F00));
            endcase
            step(($urandom % 8) != 0, $urandom % 2, a, 8'($urandom),
                 3'($urandom % 8), "R7 random");
        end
        step(0, 0, 16'h0000, 8'h00, 3'd0, "R11 drain");
        step(0, 0, 16'h0000, 8'h00, 3'd0, "R11 drain");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule